// File: doc/BRIEF.md
# Performance Monitor Counter Unit

This block counts hardware events and clock cycles for software profiling. It holds a parameterised number of 32-bit event counters and one dedicated 32-bit cycle counter. Each event counter carries an 8-bit event number that picks one line of a pulse vector `evt_in`. A counter advances by one on every cycle in which its chosen line is high and it is allowed to count.

Software reaches the unit through a simple register port. Writes take effect at the clock edge. A read returns its data one cycle after the request, marked by `bus_rvalid`. Counting is gated in two places: a global enable bit in the control register, and one enable bit per counter. The per-counter enables are changed through a write-one-to-set register and a write-one-to-clear register. Interrupt enables use a second pair of the same kind.

When a counter passes 0xFFFFFFFF it wraps to zero and latches an overflow flag. Software clears these flags by writing ones to them. `irq_out` is raised whenever a latched flag has its interrupt enable set. Event counters and their event numbers are reached indirectly, through a select register. The cycle counter has a register of its own.

Top module: `pmu_counter`

## Requirements
- R1: After reset all counters, enables, interrupt enables, overflow flags, event numbers and the select register are zero, and `irq_out` is low.
- R2: Register address 0 is control. Bit 0 is the global enable and is the only writable bit. Bits 15:11 read back the event counter count (parameter `NUM_CNT`) and ignore writes. While bit 0 is clear, no counter advances.
- R3: The cycle counter (address 9, read and write) adds one on every clock in which the global enable and enable bit 31 are both set.
- R4: Event counter n adds one on every clock in which the global enable, enable bit n and `evt_in[type_n]` are all set. An event number at or above `NUM_EVT` never counts.
- R5: Writing to address 1 sets each counter enable whose data bit is 1. Writing to address 2 clears each one whose data bit is 1. Zero bits leave the enable unchanged. Both addresses read back the enable mask. Only bits 31 and `NUM_CNT-1:0` can ever be 1.
- R6: Interrupt enables use the same scheme at address 3 (set) and address 4 (clear), with the same bit mapping as R5.
- R7: A counter that increments from 0xFFFFFFFF becomes 0 and sets its overflow flag. The flag is at address 5, bit 31 for the cycle counter and bit n for event counter n.
- R8: Writing ones to address 5 clears the matching overflow flags. If a new overflow arrives in the same cycle, the set wins.
- R9: `irq_out` is high exactly when some overflow flag and its interrupt enable are both 1.
- R10: Address 6 selects an event counter. Address 7 (count) and address 8 (event number, 8 bits) act on the selected counter. With a select value at or above `NUM_CNT`, both read as zero and ignore writes.
- R11: When a software write to a counter and an increment fall in the same cycle, the written value is stored.
- R12: Every read request returns its data with `bus_rvalid` high on the following cycle. `bus_rvalid` is low when no read was requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_re |
| evt_in | input | NUM_EVT | Event pulse lines |
| irq_out | output | 1 | Overflow interrupt |

## Verification
The embedded assertions check the following on every cycle:
- the cycle counter raises its overflow flag only when leaving all ones;
- it stays frozen while the global enable is clear;
- a write to it always wins;
- enable masks never hold unimplemented bits;
- clearing all overflow flags drops the interrupt;
- each read request is answered on the next cycle.

The following are shown only by the bench's scenarios:
- event selection by number, including an out-of-range event number;
- exact counts across runs of pulses;
- wrapping of an event counter;
- the set/clear masks leaving zero bits untouched;
- the inert behaviour of out-of-range select values.

// File: rtl/pmu_counter.sv
module pmu_counter #(
  parameter int NUM_CNT = 4,
  parameter int NUM_EVT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic               bus_re,
  input  logic [3:0]         bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  output logic               bus_rvalid,
  input  logic [NUM_EVT-1:0] evt_in,
  output logic               irq_out
);
  localparam logic [3:0] A_CTRL = 4'd0, A_ENS = 4'd1, A_ENC = 4'd2, A_IES = 4'd3,
                         A_IEC = 4'd4, A_OVF = 4'd5, A_SEL = 4'd6, A_EVC = 4'd7,
                         A_TYP = 4'd8, A_CYC = 4'd9;
  localparam logic [31:0] VALID = 32'h8000_0000 | ((32'd1 << NUM_CNT) - 32'd1);
  localparam int EW = 8;

  logic              glb_en;
  logic [31:0]       cnt_en, irq_en, ovf, ovf_set;
  logic [4:0]        sel;
  logic [31:0]       cyc;
  logic [NUM_CNT*32-1:0] ecnt_flat;
  logic [NUM_CNT*EW-1:0] etype_flat;
  logic [NUM_CNT-1:0]    ev_ovf;
  logic [255:0]      evt_ext;
  logic [31:0]       ev_rd, rd_mux;
  logic [EW-1:0]     et_rd;
  logic              cyc_wr, cyc_inc;

  assign evt_ext = {{(256-NUM_EVT){1'b0}}, evt_in};
  assign cyc_wr  = bus_we && bus_addr == A_CYC;
  assign cyc_inc = glb_en && cnt_en[31];
  assign irq_out = |(ovf & irq_en);

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_ctr
    logic [31:0]   cnt;
    logic [EW-1:0] etype;
    logic          wr, inc;
    assign wr  = bus_we && bus_addr == A_EVC && sel == 5'(g);
    assign inc = glb_en && cnt_en[g] && evt_ext[etype];
    assign ev_ovf[g] = inc && !wr && (&cnt);
    assign ecnt_flat[g*32 +: 32] = cnt;
    assign etype_flat[g*EW +: EW] = etype;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cnt   <= '0;
        etype <= '0;
      end else begin
        if (wr) cnt <= bus_wdata;
        else if (inc) cnt <= cnt + 32'd1;
        if (bus_we && bus_addr == A_TYP && sel == 5'(g)) etype <= bus_wdata[EW-1:0];
      end
    end
  end

  always_comb begin
    ovf_set = '0;
    ovf_set[31] = cyc_inc && !cyc_wr && (&cyc);
    for (int i = 0; i < NUM_CNT; i++) ovf_set[i] = ev_ovf[i];
  end

  always_comb begin
    ev_rd = '0;
    et_rd = '0;
    for (int i = 0; i < NUM_CNT; i++)
      if (sel == 5'(i)) begin
        ev_rd = ecnt_flat[i*32 +: 32];
        et_rd = etype_flat[i*EW +: EW];
      end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:       rd_mux = {16'b0, 5'(NUM_CNT), 10'b0, glb_en};
      A_ENS, A_ENC: rd_mux = cnt_en;
      A_IES, A_IEC: rd_mux = irq_en;
      A_OVF:        rd_mux = ovf;
      A_SEL:        rd_mux = {27'b0, sel};
      A_EVC:        rd_mux = ev_rd;
      A_TYP:        rd_mux = {24'b0, et_rd};
      A_CYC:        rd_mux = cyc;
      default:      rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      glb_en     <= 1'b0;
      cnt_en     <= '0;
      irq_en     <= '0;
      ovf        <= '0;
      sel        <= '0;
      cyc        <= '0;
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
    end else begin
      if (bus_we && bus_addr == A_CTRL) glb_en <= bus_wdata[0];
      if (bus_we && bus_addr == A_ENS) cnt_en <= cnt_en | (bus_wdata & VALID);
      if (bus_we && bus_addr == A_ENC) cnt_en <= cnt_en & ~bus_wdata;
      if (bus_we && bus_addr == A_IES) irq_en <= irq_en | (bus_wdata & VALID);
      if (bus_we && bus_addr == A_IEC) irq_en <= irq_en & ~bus_wdata;
      if (bus_we && bus_addr == A_SEL) sel <= bus_wdata[4:0];
      ovf <= (ovf & ~((bus_we && bus_addr == A_OVF) ? bus_wdata : 32'd0)) | ovf_set;
      if (cyc_wr) cyc <= bus_wdata;
      else if (cyc_inc) cyc <= cyc + 32'd1;
      bus_rvalid <= bus_re;
      if (bus_re) bus_rdata <= rd_mux;
    end
  end

  // R7
  cyc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf[31]) |-> $past(cyc) == 32'hFFFF_FFFF);
  // R2
  gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!glb_en && !cyc_wr) |=> cyc == $past(cyc));
  // R11
  wr_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_wr |=> cyc == $past(bus_wdata));
  // R5
  mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((cnt_en | irq_en) & ~VALID) == 32'd0);
  // R9
  irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_OVF && (&bus_wdata) && ovf_set == 32'd0) |=> !irq_out);
  // R12
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> bus_rvalid);
endmodule

// File: tb/pmu_counter_tb.sv
module pmu_counter_tb;
  localparam int NC = 4, NE = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_we = 1'b0, bus_re = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, irq_out;
  logic [NE-1:0] evt_in = '0;
  int tests = 0, fails = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  pmu_counter #(.NUM_CNT(NC), .NUM_EVT(NE)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
    .evt_in(evt_in), .irq_out(irq_out));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk); @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    bus_re = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic pulse(input logic [NE-1:0] m);
    evt_in = m;
    @(posedge clk); @(negedge clk);
    evt_in = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (bus_rvalid) begin
        if (exp_q.size() == 0) chk("R12 unexpected rvalid", 32'd1, 32'd0);
        else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    chk("R1 irq after reset", {31'b0, irq_out}, 32'd0);
    rd(4'd0, 32'h0000_2000, "R1 ctrl reset");
    rd(4'd1, 32'h0, "R1 enable reset");
    rd(4'd9, 32'h0, "R1 cycle reset");
    rd(4'd5, 32'h0, "R1 overflow reset");
    idle(1);
    chk("R12 rvalid idle", {31'b0, bus_rvalid}, 32'd0);

    wr(4'd9, 32'hFFFF_FFF0);
    wr(4'd1, 32'h8000_0000);
    rd(4'd2, 32'h8000_0000, "R5 enable readback");
    wr(4'd0, 32'd1);
    idle(20);
    wr(4'd0, 32'd0);
    rd(4'd9, 32'h0000_0005, "R3 cycle count wraps");
    rd(4'd5, 32'h8000_0000, "R7 cycle overflow flag");
    wr(4'd0, 32'h0000_F800);
    rd(4'd0, 32'h0000_2000, "R2 count field read-only");
    wr(4'd5, 32'hFFFF_FFFF);
    rd(4'd5, 32'h0, "R8 overflow cleared");

    wr(4'd0, 32'd1);
    idle(3);
    wr(4'd9, 32'd100);
    wr(4'd0, 32'd0);
    rd(4'd9, 32'd101, "R11 write wins over increment");
    wr(4'd9, 32'd7);
    idle(5);
    rd(4'd9, 32'd7, "R2 no advance when disabled");

    for (int i = 0; i < NC; i++) begin
      wr(4'd6, i);
      wr(4'd8, (i == 0) ? 3 : (i == 1) ? 5 : (i == 2) ? 200 : 3);
    end
    rd(4'd8, 32'd3, "R10 event number readback");
    wr(4'd1, 32'h0000_0007);
    wr(4'd2, 32'h8000_0000);
    rd(4'd1, 32'h0000_0007, "R5 set and clear masks");
    wr(4'd0, 32'd1);
    repeat (3) pulse(8'h08);
    repeat (2) pulse(8'h20);
    pulse(8'h28);
    pulse(8'h00);
    pulse(8'hFF);
    wr(4'd0, 32'd0);
    pulse(8'h28);
    wr(4'd6, 32'd0); rd(4'd7, 32'd5, "R4 counter0 event3");
    wr(4'd6, 32'd1); rd(4'd7, 32'd4, "R4 counter1 event5");
    wr(4'd6, 32'd2); rd(4'd7, 32'd0, "R4 out-of-range event number");
    wr(4'd6, 32'd3); rd(4'd7, 32'd0, "R5 disabled counter");

    wr(4'd6, 32'd0);
    wr(4'd7, 32'hFFFF_FFFF);
    wr(4'd0, 32'd1);
    pulse(8'h08);
    wr(4'd0, 32'd0);
    rd(4'd7, 32'd0, "R7 event counter wraps");
    rd(4'd5, 32'h1, "R7 event overflow flag");
    chk("R9 irq masked", {31'b0, irq_out}, 32'd0);
    wr(4'd3, 32'h1);
    chk("R9 irq raised", {31'b0, irq_out}, 32'd1);
    rd(4'd4, 32'h1, "R6 irq enable readback");
    wr(4'd4, 32'h1);
    chk("R6 irq enable cleared", {31'b0, irq_out}, 32'd0);
    wr(4'd3, 32'h8000_0001);
    rd(4'd3, 32'h8000_0001, "R6 irq enable set mask");
    chk("R9 irq re-raised", {31'b0, irq_out}, 32'd1);
    wr(4'd5, 32'h1);
    chk("R8 irq after clear", {31'b0, irq_out}, 32'd0);
    rd(4'd5, 32'h0, "R8 flag cleared");

    wr(4'd6, 32'd5);
    wr(4'd7, 32'h0000_1234);
    rd(4'd7, 32'h0, "R10 out-of-range count read");
    wr(4'd8, 32'd9);
    rd(4'd8, 32'h0, "R10 out-of-range type read");
    wr(4'd6, 32'd1);
    rd(4'd7, 32'd4, "R10 write ignored");
    rd(4'd8, 32'd5, "R10 type unchanged");

    wr(4'd1, 32'hFFFF_FFFF);
    rd(4'd1, 32'h8000_000F, "R5 unimplemented bits");
    wr(4'd2, 32'h0000_000A);
    rd(4'd2, 32'h8000_0005, "R5 zero bits unchanged");

    idle(3);
    chk("R12 all reads answered", exp_q.size(), 32'd0);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule